// File: doc/BRIEF.md
# Threshold-Table Non-Uniform Quantizer

This block converts a stream of signed 12-bit baseband samples into 5-bit or 6-bit converter codes. The decision boundaries between output levels are not evenly spaced. Each boundary is a programmed value, so the levels can be packed tightly near zero and spread out toward full scale, following A-law or minimum-mean-square-error spacing. The code is therefore found by comparing against a threshold table, not by dropping low bits. The boundaries are computed offline, usually as the midpoints between neighbouring output levels. They are then written into the table before streaming starts.

During streaming, each valid sample is compared with every table entry at the same time. The output code is the number of active entries that are less than or equal to the sample. Software is expected to write the entries in ascending order. Each entry is held independently, so the table may be asymmetric about zero. A resolution select travels with every sample and chooses between 6-bit codes, which use the whole table, and 5-bit codes, which use only the lower part of it.

Top module: `nuq_quantizer`

## Requirements
- R1: For a valid sample, the output code equals the number of active table entries T[i] for which T[i] <= sample, with both values compared as 12-bit two's complement.
- R2: When `resWide` = 1 with the sample, all 63 entries (addresses 0..62) are active, and the code lies in the range 0..63.
- R3: When `resWide` = 0 with the sample, only entries 0..30 are active, bit 5 of the code is 0, and the code lies in the range 0..31.
- R4: A sample presented with `inValid` high at a rising edge produces `outValid` high, with its code, exactly two rising edges later. A new sample may be presented every cycle.
- R5: While `outValid` is low, `outCode` keeps the last code that was delivered.
- R6: With `thrWrEn` high and `thrAddr` in 0..62, the entry at `thrAddr` takes `thrData` at the rising edge. A sample presented in the same cycle as the write still sees the old value; samples in later cycles see the new value.
- R7: A write to `thrAddr` = 63 changes no table entry.
- R8: The resolution is taken per sample. Consecutive samples with different `resWide` values are each coded in their own mode.
- R9: While `rstN` is low, `outValid` and `outCode` are 0 and every table entry is cleared to 0. With the table cleared, sample 0 codes to 63 (wide) or 31 (narrow), and sample -1 codes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Sample qualifier |
| inSample | input | 12 | Two's complement sample |
| resWide | input | 1 | 1 = 6-bit code, 0 = 5-bit code, taken with the sample |
| thrWrEn | input | 1 | Threshold write strobe |
| thrAddr | input | 6 | Threshold entry index (0..62 valid) |
| thrData | input | 12 | Two's complement threshold value |
| outValid | output | 1 | Code qualifier |
| outCode | output | 6 | Output code |

## Verification
The code and the valid flag for a sample appear two rising edges after the edge that captures the sample. A table write changes the comparison from the next captured sample onward. The bench drives inputs on falling edges. It holds each expected result in a two-deep shift register, so every falling edge compares the outputs with the expectation from two drives earlier. The expectation is computed when the sample is driven, from the bench's own table model and before any write in that cycle is applied to the model. This reproduces the same-cycle write rule exactly.

// File: rtl/nuq_pkg.sv
package nuq_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic tblWr;    // in-range table write this cycle
    logic capture;  // load compare stage
    logic emit;     // load code stage
  } nuqStrobe_t;
endpackage

// File: rtl/nuq_ctrl.sv
module nuq_ctrl
  import nuq_pkg::*;
#(
  parameter int MAX_BITS = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic                thrWrEn,
  input  logic [MAX_BITS-1:0] thrAddr,
  output nuqStrobe_t          stb,
  output logic                outValid
);
  localparam int NUM_THR = (1 << MAX_BITS) - 1;

  logic v1Q, v2Q;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1Q <= 1'b0;
      v2Q <= 1'b0;
    end else begin
      v1Q <= inValid;
      v2Q <= v1Q;
    end
  end

  always_comb begin
    stb.tblWr   = thrWrEn && (thrAddr < MAX_BITS'(NUM_THR));
    stb.capture = inValid;
    stb.emit    = v1Q;
  end

  assign outValid = v2Q;

  // R4: a captured sample yields a valid code two edges later
  p_latency_r4: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);
  // R4: no code appears without a sample two edges earlier
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##2 !outValid);
endmodule

// File: rtl/nuq_datapath.sv
module nuq_datapath
  import nuq_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int MAX_BITS = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  nuqStrobe_t          stb,
  input  logic [SAMPLE_W-1:0] inSample,
  input  logic                resWide,
  input  logic [MAX_BITS-1:0] wrAddr,
  input  logic [SAMPLE_W-1:0] wrData,
  input  logic                validMon,
  output logic [MAX_BITS-1:0] outCode
);
  localparam int NUM_THR    = (1 << MAX_BITS) - 1;
  localparam int NUM_NARROW = (1 << (MAX_BITS - 1)) - 1;

  logic signed [SAMPLE_W-1:0] thrTbl [NUM_THR];
  logic [NUM_THR-1:0] geVec;
  logic [NUM_THR-1:0] cmpQ;
  logic               wideQ;
  logic               codeWideQ;
  logic [MAX_BITS-1:0] cnt;
  logic [MAX_BITS-1:0] codeNext;

  // Threshold registers and parallel comparators
  for (genvar i = 0; i < NUM_THR; i++) begin : g_entry
    localparam bit IN_NARROW = (i < NUM_NARROW);

    always_ff @(posedge clk) begin
      if (!rstN)
        thrTbl[i] <= '0;
      else if (stb.tblWr && (wrAddr == MAX_BITS'(i)))
        thrTbl[i] <= $signed(wrData);
    end

    assign geVec[i] = ($signed(inSample) >= thrTbl[i]) && (resWide || IN_NARROW);
  end

  // Stage 1: compare vector and mode
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpQ  <= '0;
      wideQ <= 1'b0;
    end else if (stb.capture) begin
      cmpQ  <= geVec;
      wideQ <= resWide;
    end
  end

  function automatic logic [MAX_BITS-1:0] countSet(input logic [NUM_THR-1:0] vec);
    logic [MAX_BITS-1:0] acc;
    acc = '0;
    for (int j = 0; j < NUM_THR; j++)
      acc = acc + {{(MAX_BITS-1){1'b0}}, vec[j]};
    return acc;
  endfunction

  always_comb begin
    cnt      = countSet(cmpQ);
    codeNext = wideQ ? cnt : {1'b0, cnt[MAX_BITS-2:0]};
  end

  // Stage 2: code register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outCode   <= '0;
      codeWideQ <= 1'b0;
    end else if (stb.emit) begin
      outCode   <= codeNext;
      codeWideQ <= wideQ;
    end
  end

  // R5: the code holds while no valid code is delivered
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !validMon |-> $stable(outCode));
  // R3: a narrow-mode sample never exceeds the narrow range
  p_narrow_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.emit && !wideQ) |=> (outCode <= MAX_BITS'(NUM_NARROW)));
  // R2: the top code bit only appears for a wide-mode sample
  p_msb_wide_r2: assert property (@(posedge clk) disable iff (!rstN)
    (validMon && outCode[MAX_BITS-1]) |-> codeWideQ);
endmodule

// File: rtl/nuq_quantizer.sv
module nuq_quantizer
  import nuq_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int MAX_BITS = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inSample,
  input  logic                resWide,
  input  logic                thrWrEn,
  input  logic [MAX_BITS-1:0] thrAddr,
  input  logic [SAMPLE_W-1:0] thrData,
  output logic                outValid,
  output logic [MAX_BITS-1:0] outCode
);
  nuqStrobe_t stb;

  nuq_ctrl #(.MAX_BITS(MAX_BITS)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .thrWrEn (thrWrEn),
    .thrAddr (thrAddr),
    .stb     (stb),
    .outValid(outValid)
  );

  nuq_datapath #(.SAMPLE_W(SAMPLE_W), .MAX_BITS(MAX_BITS)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .inSample(inSample),
    .resWide (resWide),
    .wrAddr  (thrAddr),
    .wrData  (thrData),
    .validMon(outValid),
    .outCode (outCode)
  );
endmodule

// File: tb/tb_nuq_quantizer.sv
module tb_nuq_quantizer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [11:0] inSample = '0;
  logic resWide = 1'b0;
  logic thrWrEn = 1'b0;
  logic [5:0] thrAddr = '0;
  logic [11:0] thrData = '0;
  logic outValid;
  logic [5:0] outCode;

  always #5 clk = ~clk;

  nuq_quantizer dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
    .resWide(resWide), .thrWrEn(thrWrEn), .thrAddr(thrAddr), .thrData(thrData),
    .outValid(outValid), .outCode(outCode)
  );

  int total = 0;
  int failed = 0;
  int model [63];
  int lastCode = 0;
  bit p1v = 0, p2v = 0;
  int p1c = 0, p2c = 0;
  string p1t = "R5", p2t = "R5";

  function automatic int thrVal(int i);
    int k = i - 31;
    return (k < 0) ? (-2 * k * k - 3) : (2 * k * k);
  endfunction

  function automatic int expCode(int s, bit w);
    int n = w ? 63 : 31;
    int c = 0;
    for (int i = 0; i < n; i++) if (s >= model[i]) c++;
    return c;
  endfunction

  task automatic check(bit expV, int expC, string tag);
    total++;
    if (outValid !== expV || int'(outCode) != expC) begin
      failed++;
      $display("FAIL %s: valid=%0b code=%0d expected valid=%0b code=%0d",
               tag, outValid, outCode, expV, expC);
    end
  endtask

  task automatic step(bit v, int s, bit w, bit we, int a, int d, string tag);
    @(negedge clk);
    if (p2v) begin
      check(1'b1, p2c, p2t);
      lastCode = p2c;
    end else begin
      check(1'b0, lastCode, "R5");
    end
    p2v = p1v; p2c = p1c; p2t = p1t;
    inValid = v; inSample = 12'(s); resWide = w;
    thrWrEn = we; thrAddr = 6'(a); thrData = 12'(d);
    p1v = v; p1c = v ? expCode(s, w) : 0; p1t = tag;
    if (we && a < 63) model[a] = d;
  endtask

  initial begin
    repeat (500000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 63; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1'b0, 0, "R9");
    rstN = 1'b1;

    // R9: cleared table
    step(1, -1, 1, 0, 0, 0, "R9");
    step(1, 0, 1, 0, 0, 0, "R9");
    step(1, 0, 0, 0, 0, 0, "R9");
    step(1, 2047, 0, 0, 0, 0, "R9");

    // Program a non-uniform, asymmetric ascending table
    for (int i = 0; i < 63; i++) step(0, 0, 0, 1, i, thrVal(i), "R5");
    // R7: out-of-range address must not disturb any entry
    step(0, 0, 0, 1, 63, -2048, "R7");
    step(1, -2048, 1, 0, 0, 0, "R7");
    step(1, 2047, 1, 0, 0, 0, "R7");

    // R1 R2 R4: full wide sweep with periodic gaps
    for (int k = 0; k < 4096; k++)
      step((k % 7) != 3, k - 2048, 1, 0, 0, 0, "R1 R2 R4");
    // R1 R3: full narrow sweep
    for (int k = 0; k < 4096; k++)
      step((k % 5) != 2, k - 2048, 0, 0, 0, 0, "R1 R3");
    // R8: alternating resolution per sample
    for (int k = 0; k < 205; k++)
      step(1, -2048 + k * 20, k[0], 0, 0, 0, "R8");

    // R6: write in the same cycle as a sample, then the next sample
    step(1, 100, 1, 1, 40, 50, "R6");
    step(1, 100, 1, 0, 0, 0, "R6");
    step(1, 50, 1, 0, 0, 0, "R6");
    step(1, 49, 1, 0, 0, 0, "R6");

    // Flush the pipeline
    step(0, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, "R5");

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule